// File: doc/BRIEF.md
# Sample-Clocked Frequency Meter

This block measures an unknown digital input against a known timebase. It runs on one system clock. A timebase tick strobe (`tb_tick_i`) marks each timebase rising edge. The measured signal and a user-supplied sample clock are asynchronous. Each passes through a two-flop synchronizer, and its rising edges are detected in the system clock domain.

In sampled mode the block counts two things between consecutive sample clock rising edges: timebase ticks and rising edges of the measured signal. On every sample clock edge after the arming edge, it pushes both counts as one result. Software then forms the average frequency as signal edges divided by elapsed timebase time.

In implicit mode the measured signal's own rising edges bound the interval. Each full input cycle then yields one period value in timebase ticks.

Results go into a small show-ahead FIFO. Software reads them through a valid/pop port. Counters saturate and flag the sample. A result that finds the FIFO full is dropped and raises a sticky overrun flag.

Top module: `freq_meter`

## Requirements
- R1: In sampled mode (mode_i = 0), the timebase field of a result equals the number of cycles with tb_tick_i high, counted from the cycle of the previous sample clock edge detection up to but excluding the cycle of the current one. A tick in the detection cycle belongs to the new interval.
- R2: In sampled mode, the signal field equals the number of signal rising edges detected over the same interval. An edge detected in the same cycle as a sample edge belongs to the new interval.
- R3: After en_i rises, or after mode_i changes, the first reference edge only arms the counters and produces no result. The reference edge is the sample clock in sampled mode and the measured signal in implicit mode.
- R4: While en_i is low, no results are produced and the block returns to the unarmed state.
- R5: In implicit mode (mode_i = 1), every signal rising edge after arming pushes one result. Its timebase field is the tick count since the previous signal edge, with the same edge-cycle rule as R1, and its signal field is 1.
- R6: Each count saturates at all ones. If any tick or edge arrives while a count is already saturated, the result's overflow bit is 1; otherwise the overflow bit is 0.
- R7: A result word is {ovf, sig_cnt, tb_cnt}: tb_cnt in bits [CNT_W-1:0], sig_cnt in bits [2*CNT_W-1:CNT_W], ovf in bit 2*CNT_W.
- R8: Results are read in the order they were produced. rd_valid_o is high while the FIFO holds a result, rd_data_o shows the oldest result, and rd_en_i pops it.
- R9: A result produced while the FIFO is full is discarded, and the FIFO contents are unchanged. overrun_o goes high and stays high until reset.
- R10: After reset, rd_valid_o and overrun_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Measurement enable |
| mode_i | input | 1 | 0 = sampled mode, 1 = implicit period mode |
| tb_tick_i | input | 1 | Timebase rising edge strobe, one cycle per edge |
| sig_i | input | 1 | Measured signal, asynchronous |
| smp_clk_i | input | 1 | Sample clock, asynchronous |
| rd_en_i | input | 1 | Pop the oldest result |
| rd_valid_o | output | 1 | FIFO holds at least one result |
| rd_data_o | output | 2*CNT_W+1 | Oldest result {ovf, sig_cnt, tb_cnt} |
| overrun_o | output | 1 | Sticky: a result was dropped on a full FIFO |

## Verification
Sampled mode is driven with several ratios of sample interval to signal period and with different tick divisors. This separates errors in the timebase count from errors in the signal edge count. It also shows that a signal whose period equals the sample interval gives exactly one edge per interval, so no edge is lost or counted twice at an interval boundary. Implicit mode is run with two periods and two tick divisors, which checks that the period is measured per input cycle and that the signal field is fixed at one. Three directed runs cover the remaining cases: an interval long enough to saturate a narrow counter, a run with enable held low, and a burst of results into a FIFO that is never read.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;
  typedef enum logic {
    MODE_SAMPLED  = 1'b0,
    MODE_IMPLICIT = 1'b1
  } meas_mode_e;
endpackage

// File: rtl/fm_sync_edge.sv
module fm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], d_i};
  end

  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/fm_core.sv
module fm_core
  import freq_meter_pkg::*;
#(
  parameter int CNT_W  = 32,
  localparam int WORD_W = 2*CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  meas_mode_e        mode_i,
  input  logic              tick_i,
  input  logic              smp_rise_i,
  input  logic              sig_rise_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  meas_mode_e       mode_q;
  logic             armed_q, ovf_q;
  logic [CNT_W-1:0] tb_cnt_q, sig_cnt_q;
  logic             ref_rise, live, sig_inc;

  assign live     = en_i && (mode_i == mode_q);
  assign ref_rise = (mode_i == MODE_IMPLICIT) ? sig_rise_i : smp_rise_i;
  assign sig_inc  = (mode_i == MODE_SAMPLED) && sig_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_SAMPLED;
      armed_q   <= 1'b0;
      ovf_q     <= 1'b0;
      tb_cnt_q  <= '0;
      sig_cnt_q <= '0;
    end else if (!live) begin
      mode_q    <= mode_i;
      armed_q   <= 1'b0;
      ovf_q     <= 1'b0;
      tb_cnt_q  <= '0;
      sig_cnt_q <= '0;
    end else if (ref_rise) begin
      // edge cycle opens the new interval
      armed_q   <= 1'b1;
      ovf_q     <= 1'b0;
      tb_cnt_q  <= tick_i  ? CNT_ONE : '0;
      sig_cnt_q <= sig_inc ? CNT_ONE : '0;
    end else begin
      if (tick_i) begin
        if (tb_cnt_q == CNT_MAX) ovf_q <= 1'b1;
        else                     tb_cnt_q <= tb_cnt_q + CNT_ONE;
      end
      if (sig_inc) begin
        if (sig_cnt_q == CNT_MAX) ovf_q <= 1'b1;
        else                      sig_cnt_q <= sig_cnt_q + CNT_ONE;
      end
    end
  end

  assign push_o = live && ref_rise && armed_q;
  assign word_o = {ovf_q, (mode_i == MODE_IMPLICIT) ? CNT_ONE : sig_cnt_q, tb_cnt_q};

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !ref_rise && tb_cnt_q == CNT_MAX) |=> (tb_cnt_q == CNT_MAX)) else $error("sat"); // R6
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !ref_rise && tick_i && tb_cnt_q == CNT_MAX) |=> ovf_q) else $error("ovf"); // R6
  AST_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !armed_q) else $error("disarm"); // R4
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> (tb_cnt_q <= CNT_ONE && !ovf_q)) else $error("restart"); // R1
endmodule

// File: rtl/fm_fifo.sv
module fm_fifo #(
  parameter int W     = 65,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_i,
  output logic         valid_o,
  output logic [W-1:0] rd_data_o,
  output logic         drop_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST     = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, do_wr, do_rd;

  assign full    = (cnt_q == FULL_CNT);
  assign do_wr   = wr_i && !full;
  assign do_rd   = rd_i && (cnt_q != '0);
  assign drop_o  = wr_i && full;
  assign valid_o = (cnt_q != '0);
  assign rd_data_o = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_wr) begin
        mem_q[wp_q] <= wr_data_i;
        wp_q <= (wp_q == LAST) ? '0 : wp_q + PTR_W'(1);
      end
      if (do_rd) rp_q <= (rp_q == LAST) ? '0 : rp_q + PTR_W'(1);
      cnt_q <= cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd);
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT) else $error("bound"); // R8
  AST_DROP_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full && !rd_i) |=> (cnt_q == FULL_CNT && $stable(wp_q))) else $error("drop"); // R9
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import freq_meter_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int SYNC_STG   = 2,
  localparam int WORD_W    = 2*CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic              tb_tick_i,
  input  logic              sig_i,
  input  logic              smp_clk_i,
  input  logic              rd_en_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              overrun_o
);
  logic              smp_rise, sig_rise, push, drop;
  logic [WORD_W-1:0] word;
  logic              overrun_q;

  fm_sync_edge #(.STAGES(SYNC_STG)) u_smp_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(smp_clk_i), .rise_o(smp_rise));
  fm_sync_edge #(.STAGES(SYNC_STG)) u_sig_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sig_i), .rise_o(sig_rise));

  fm_core #(.CNT_W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(meas_mode_e'(mode_i)),
    .tick_i(tb_tick_i), .smp_rise_i(smp_rise), .sig_rise_i(sig_rise),
    .push_o(push), .word_o(word));

  fm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(push), .wr_data_i(word),
    .rd_i(rd_en_i), .valid_o(rd_valid_o), .rd_data_o(rd_data_o), .drop_o(drop));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   overrun_q <= 1'b0;
    else if (drop) overrun_q <= 1'b1;
  end
  assign overrun_o = overrun_q;

  AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o) else $error("sticky"); // R9
  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && rd_valid_o && drop) |=> overrun_o) else $error("overrun"); // R9
endmodule

// File: tb/freq_meter_tb.sv
module freq_meter_tb;
  localparam int CW = 8;
  localparam int DEPTH = 4;
  localparam int WW = 2*CW + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, mode = 1'b0, tick = 1'b0, sig = 1'b0, smp = 1'b0, rd_en = 1'b0;
  logic rd_valid, overrun;
  logic [WW-1:0] rd_data;
  int n_run = 0, n_fail = 0, cyc = 0;
  logic [WW-1:0] got [8];
  int n_got;

  always #5 clk = ~clk;

  freq_meter #(.CNT_W(CW), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .tb_tick_i(tick),
    .sig_i(sig), .smp_clk_i(smp), .rd_en_i(rd_en), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .overrun_o(overrun));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // m: mode, s: sample period, p: signal period, d: tick divisor, n: intervals
  task automatic run_pat(input int m, input int s, input int p, input int d, input int n);
    int len;
    len = (m == 0) ? n*s + 6 : p/2 + n*p + 6;
    @(negedge clk);
    mode = m[0];
    @(negedge clk);
    for (int c = 0; c < len; c++) begin
      smp  = (m == 0) && ((c % s) < s/2);
      sig  = ((c + p/2) % p) < p/2;
      tick = (c % d) == 0;
      @(negedge clk);
    end
    smp = 1'b0; sig = 1'b0; tick = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic drain();
    n_got = 0;
    forever begin
      @(negedge clk);
      if (!rd_valid || n_got == 8) break;
      got[n_got] = rd_data;
      n_got++;
      rd_en = 1'b1;
      @(posedge clk);
      #1 rd_en = 1'b0;
    end
  endtask

  task automatic chk_set(input string req, input int n_exp, input int tb_e,
                         input int sg_e, input int ov_e);
    chk({req, " count (R3)"}, n_got, n_exp);
    for (int i = 0; i < n_got; i++) begin
      chk({req, " tb field (R1/R5/R7)"}, int'(got[i][CW-1:0]), tb_e);
      chk({req, " sig field (R2/R7)"}, int'(got[i][2*CW-1:CW]), sg_e);
      chk({req, " ovf bit (R6)"}, int'(got[i][2*CW]), ov_e);
    end
  endtask

  // {mode, s, p, d, exp_tb, exp_sig}
  localparam int NV = 6;
  localparam int VEC [NV][6] = '{
    '{0, 40,  8, 1, 40, 5},
    '{0, 60, 12, 3, 20, 5},
    '{0, 48, 16, 2, 24, 3},
    '{0, 30, 30, 1, 30, 1},
    '{1,  0, 20, 1, 20, 1},
    '{1,  0, 36, 4,  9, 1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 rd_valid after reset", int'(rd_valid), 0);
    chk("R10 overrun after reset", int'(overrun), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      en = 1'b1;
      run_pat(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 3);
      en = 1'b0;
      drain();
      // R1 R2 R5 R8: three results in order, first edge only arms (R3)
      chk_set($sformatf("vec%0d", v), 3, VEC[v][4], VEC[v][5], 0);
    end

    // R4: enable low, no results
    en = 1'b0;
    run_pat(0, 20, 4, 1, 4);
    chk("R4 no result while disabled", int'(rd_valid), 0);

    // R6: saturation of timebase count at 255
    en = 1'b1;
    run_pat(0, 300, 10, 1, 3);
    en = 1'b0;
    drain();
    chk_set("R6 saturate", 3, 255, 30, 1);
    chk("R9 overrun not spurious", int'(overrun), 0);

    // R9: six results into a depth-4 FIFO, never read
    en = 1'b1;
    run_pat(0, 20, 4, 1, 6);
    en = 1'b0;
    chk("R9 overrun set", int'(overrun), 1);
    drain();
    chk_set("R9 kept entries", DEPTH, 20, 5, 0);
    chk("R9 overrun sticky", int'(overrun), 1);
    chk("R8 empty after drain", int'(rd_valid), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule